// File: doc/BRIEF.md
# Level-2 Interrupt Aggregator

This block collects a bank of level-sensitive interrupt sources into a single request line toward a parent interrupt controller. Each source is synchronized and then latched into a status bit. A status bit stays set until software acknowledges it. A separate mask register gates which latched bits may raise the parent line. A mask bit of one means the source is disabled.

Software never needs a read-modify-write sequence. Status and mask each have one address where written ones set bits and another where written ones clear bits. Bits written as zero are left as they were. Software may also force status bits to raise an interrupt itself. Both registers can be read back through a simple 32-bit register port with one cycle of read latency.

Top module: `irq_gather`

## Requirements
- R1: While reset is held and after it is released, the mask register reads all ones, the status register reads zero and `irq_o` is low.
- R2: A source held high sets its status bit exactly SYNC_STAGES+1 clock edges after it is first sampled high (3 with defaults). The bit stays set after the source returns low.
- R3: A write to byte offset 0x08 clears every status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R4: If a source is still high (after synchronization) in the cycle of a clear write to its bit, the hardware set wins and the bit stays set.
- R5: A write to byte offset 0x04 sets every status bit whose data bit is 1 and leaves the others unchanged.
- R6: A write to byte offset 0x10 sets mask bits (1 = source disabled). A write to byte offset 0x14 clears mask bits (source enabled). Data bits of 0 leave mask bits unchanged.
- R7: `irq_o` is high exactly when status AND NOT mask is nonzero. It reflects a register write from the cycle after that write, and it is driven from a flop.
- R8: A read at byte offset 0x00 returns status and a read at 0x0C returns mask, on `rdata` in the cycle after `rd_en`. A read at any other offset returns zero.
- R9: With sources low, writing all ones to 0x10 and then all ones to 0x08 leaves mask all ones, status zero and `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt sources, may be asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register access |
| wdata | input | NUM_SRC | Write data, one bit per source |
| rdata | output | NUM_SRC | Read data, valid the cycle after `rd_en` |
| irq_o | output | 1 | Request line to the parent controller |

## Verification
The embedded assertions check on every cycle that:
- set bits are sticky unless cleared;
- a synchronized source always leaves its bit set, whatever write arrives;
- mask writes move exactly the written bits;
- the request line always equals the OR of the unmasked pending bits;
- reads at write-only offsets return zero;
- reset values are correct.

The bench's scenarios are needed to show the rest:
- the exact capture latency through the synchronizer;
- acknowledge behaviour when clear and set data cover a mix of bits;
- the set-wins race with an input still held high;
- the full disable-everything sequence, seen through read-back values.

// File: rtl/irq_gather_pkg.sv
// Package: shared offsets and the decoded write operation for irq_gather.
// Assumes byte-addressed 32-bit registers; only the listed offsets decode.
package irq_gather_pkg;

    localparam int unsigned OFF_STAT     = 'h00;
    localparam int unsigned OFF_STAT_SET = 'h04;
    localparam int unsigned OFF_STAT_CLR = 'h08;
    localparam int unsigned OFF_MASK     = 'h0C;
    localparam int unsigned OFF_MASK_SET = 'h10;
    localparam int unsigned OFF_MASK_CLR = 'h14;

    typedef enum logic [2:0] {
        WOP_NONE     = 3'd0,
        WOP_STAT_SET = 3'd1,
        WOP_STAT_CLR = 3'd2,
        WOP_MASK_SET = 3'd3,
        WOP_MASK_CLR = 3'd4
    } wr_op_e;

endpackage

// File: rtl/irq_gather_sync.sv
// Module: multi-stage synchronizer for the source bank.
// Assumes each source is a level held long enough to be sampled; STAGES >= 1.
module irq_gather_sync #(
    parameter int unsigned N      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    logic [N-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First flop: capture the raw asynchronous levels.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= din;
            end
        end else begin : g_next
            // Later flops: pass the previous stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/irq_gather_regs.sv
// Module: status and mask register banks with the request flop.
// Assumes at most one software write per cycle (one decoded op).
// A hardware level set takes priority over a software clear of the same bit.
module irq_gather_regs
    import irq_gather_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_lvl,
    input  wr_op_e       op,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] st_q,
    output logic [N-1:0] mk_q,
    output logic         irq_q
);

    logic [N-1:0] st_set, st_clr, mk_set, mk_clr;
    logic [N-1:0] st_nxt, mk_nxt;

    // Expand the decoded op into per-bit set/clear vectors.
    always_comb begin
        st_set = (op == WOP_STAT_SET) ? wdata : '0;
        st_clr = (op == WOP_STAT_CLR) ? wdata : '0;
        mk_set = (op == WOP_MASK_SET) ? wdata : '0;
        mk_clr = (op == WOP_MASK_CLR) ? wdata : '0;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Per-bit next state: sets (hardware or software) override a clear.
        always_comb begin
            st_nxt[i] = (st_q[i] & ~st_clr[i]) | st_set[i] | hw_lvl[i];
            mk_nxt[i] = (mk_q[i] | mk_set[i]) & ~mk_clr[i];
        end

        // Per-bit storage: status resets clear, mask resets to disabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[i] <= 1'b0;
                mk_q[i] <= 1'b1;
            end else begin
                st_q[i] <= st_nxt[i];
                mk_q[i] <= mk_nxt[i];
            end
        end
    end

    // Request flop fed from next-state values, so it changes together with the registers.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(st_nxt & ~mk_nxt);
    end

    AST_RESET_VALUES: assert property (@(posedge clk)
        !rst_n |=> (mk_q == '1 && st_q == '0 && !irq_q)); // R1

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q) & ~$past(st_clr) & ~st_q) == '0)); // R3

    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(hw_lvl) & ~st_q) == '0)); // R4

    AST_SW_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == WOP_STAT_SET) |=> ((st_q & $past(wdata)) == $past(wdata))); // R5

    AST_MASK_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (op == WOP_MASK_SET) |=> (mk_q == ($past(mk_q) | $past(wdata)))); // R6

    AST_MASK_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (op == WOP_MASK_CLR) |=> (mk_q == ($past(mk_q) & ~$past(wdata)))); // R6

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op != WOP_MASK_SET && op != WOP_MASK_CLR) |=> $stable(mk_q)); // R6

endmodule

// File: rtl/irq_gather_rdport.sv
// Module: registered read port.
// Assumes rd_en is a single-cycle strobe; rdata returns zero when no valid read.
module irq_gather_rdport
    import irq_gather_pkg::*;
#(
    parameter int unsigned N      = 32,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      st_q,
    input  logic [N-1:0]      mk_q,
    output logic [N-1:0]      rdata
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);

    logic [N-1:0] rd_mux;

    // Select the readable register; every other offset reads as zero.
    always_comb begin
        rd_mux = '0;
        if (rd_en) begin
            if (addr == A_STAT)      rd_mux = st_q;
            else if (addr == A_MASK) rd_mux = mk_q;
        end
    end

    // One cycle of read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_mux;
    end

    AST_WRITE_ONLY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != A_STAT && addr != A_MASK) |=> (rdata == '0)); // R8

    AST_MASK_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_MASK) |=> (rdata == $past(mk_q))); // R8

endmodule

// File: rtl/irq_gather.sv
// Module: level-2 interrupt aggregator top.
// Decodes register writes into one set/clear op and synchronizes the sources.
// Drives a flopped request line to the parent controller.
// Assumes wr_en and rd_en are not both asserted in the same cycle.
module irq_gather
    import irq_gather_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 32,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] rdata,
    output logic               irq_o
);

    localparam logic [ADDR_W-1:0] A_SSET = ADDR_W'(OFF_STAT_SET);
    localparam logic [ADDR_W-1:0] A_SCLR = ADDR_W'(OFF_STAT_CLR);
    localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(OFF_MASK_SET);
    localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(OFF_MASK_CLR);

    logic [NUM_SRC-1:0] src_sync;
    logic [NUM_SRC-1:0] st_q, mk_q;
    wr_op_e             wop;

    // Decode a write strobe and offset into one register operation.
    always_comb begin
        wop = WOP_NONE;
        if (wr_en) begin
            unique case (addr)
                A_SSET:  wop = WOP_STAT_SET;
                A_SCLR:  wop = WOP_STAT_CLR;
                A_MSET:  wop = WOP_MASK_SET;
                A_MCLR:  wop = WOP_MASK_CLR;
                default: wop = WOP_NONE;
            endcase
        end
    end

    irq_gather_sync #(.N(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (src_i),
        .dout  (src_sync)
    );

    irq_gather_regs #(.N(NUM_SRC)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_lvl (src_sync),
        .op     (wop),
        .wdata  (wdata),
        .st_q   (st_q),
        .mk_q   (mk_q),
        .irq_q  (irq_o)
    );

    irq_gather_rdport #(.N(NUM_SRC), .ADDR_W(ADDR_W)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_en),
        .addr  (addr),
        .st_q  (st_q),
        .mk_q  (mk_q),
        .rdata (rdata)
    );

    AST_IRQ_TRACKS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (irq_o == (|(st_q & ~mk_q)))); // R7

    AST_IRQ_AFTER_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wop == WOP_MASK_SET && wdata == '1) |=> !irq_o); // R9

endmodule

// File: tb/irq_gather_bench.sv
// Bench for irq_gather: a vector table walked by one loop, then directed cases.
module irq_gather_bench;

    localparam int N = 32;
    localparam logic [4:0] A_STAT = 5'h00, A_SSET = 5'h04, A_SCLR = 5'h08,
                           A_MASK = 5'h0C, A_MSET = 5'h10, A_MCLR = 5'h14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_i = '0;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk; // 200 MHz

    irq_gather u_irq_gather (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        is_wr;
        logic [4:0]  a;
        logic [31:0] d;
        logic [31:0] exp_rd;   // checked only for reads
        logic        exp_irq;
    } vec_t;

    localparam vec_t TBL [12] = '{
        '{1'b1, A_MCLR, 32'h0000_00FF, 32'h0, 1'b0},        // R6 enable low byte
        '{1'b0, A_MASK, 32'h0,         32'hFFFF_FF00, 1'b0}, // R6 readback
        '{1'b1, A_SSET, 32'h0000_0101, 32'h0, 1'b1},        // R5 force bits 0 and 8
        '{1'b0, A_STAT, 32'h0,         32'h0000_0101, 1'b1}, // R5 R8 readback
        '{1'b1, A_SCLR, 32'h0000_0001, 32'h0, 1'b0},        // R3 ack bit 0, bit 8 masked
        '{1'b0, A_STAT, 32'h0,         32'h0000_0100, 1'b0}, // R3 others kept
        '{1'b1, A_MCLR, 32'h0000_0100, 32'h0, 1'b1},        // R7 unmask pending bit 8
        '{1'b0, A_MASK, 32'h0,         32'hFFFF_FE00, 1'b1}, // R6 readback
        '{1'b1, A_MSET, 32'h0000_0100, 32'h0, 1'b0},        // R7 mask again
        '{1'b0, A_SSET, 32'h0,         32'h0, 1'b0},        // R8 write-only offset reads zero
        '{1'b1, A_SCLR, 32'h0000_0100, 32'h0, 1'b0},        // R3 ack bit 8
        '{1'b0, A_STAT, 32'h0,         32'h0, 1'b0}         // R3 empty
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one access at a negedge; return at the next negedge with results visible.
    task automatic op(input logic w, input logic [4:0] a, input logic [31:0] d);
        wr_en = w; rd_en = ~w; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 irq during reset", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        op(1'b0, A_MASK, '0); chk("R1 mask reset", rdata, 32'hFFFF_FFFF);
        op(1'b0, A_STAT, '0); chk("R1 status reset", rdata, 32'h0);
        chk("R1 irq reset", {31'b0, irq_o}, 32'h0);

        for (int i = 0; i < 12; i++) begin
            op(TBL[i].is_wr, TBL[i].a, TBL[i].d);
            if (!TBL[i].is_wr) chk($sformatf("table %0d rdata", i), rdata, TBL[i].exp_rd);
            chk($sformatf("table %0d irq", i), {31'b0, irq_o}, {31'b0, TBL[i].exp_irq});
        end

        // R2: capture latency through the synchronizer, then stickiness.
        op(1'b1, A_MCLR, 32'h0000_0008);
        src_i[3] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R2 not yet captured", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R2 captured after 3 edges", {31'b0, irq_o}, 32'h1);
        src_i[3] = 1'b0;
        repeat (4) @(negedge clk);
        op(1'b0, A_STAT, '0); chk("R2 sticky after source drops", rdata, 32'h0000_0008);
        op(1'b1, A_SCLR, 32'h0000_0008);
        chk("R3 ack drops irq", {31'b0, irq_o}, 32'h0);

        // R4: clear while the source is still high; set wins.
        src_i[5] = 1'b1;
        repeat (4) @(negedge clk);
        op(1'b1, A_SCLR, 32'h0000_0020);
        op(1'b0, A_STAT, '0); chk("R4 set wins over clear", rdata, 32'h0000_0020);
        src_i[5] = 1'b0;
        repeat (4) @(negedge clk);
        op(1'b1, A_SCLR, 32'h0000_0020);
        op(1'b0, A_STAT, '0); chk("R4 clears once source low", rdata, 32'h0);

        // R9: disable-everything sequence.
        op(1'b1, A_SSET, 32'hFFFF_FFFF);
        chk("R7 forced pending raises irq", {31'b0, irq_o}, 32'h1);
        op(1'b1, A_MSET, 32'hFFFF_FFFF);
        chk("R9 irq low after mask all", {31'b0, irq_o}, 32'h0);
        op(1'b1, A_SCLR, 32'hFFFF_FFFF);
        op(1'b0, A_STAT, '0); chk("R9 status empty", rdata, 32'h0);
        op(1'b0, A_MASK, '0); chk("R9 mask all ones", rdata, 32'hFFFF_FFFF);
        chk("R9 irq low", {31'b0, irq_o}, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule